// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It runs two predictors side by side. The local one keeps a short outcome history for each branch, found by the low bits of the branch address, and uses that history to pick a 2-bit counter. The global one uses a single shift register holding the most recent outcomes of all branches to pick its own 2-bit counter. A third table of 2-bit counters, also indexed by low address bits, records which of the two has been more reliable for that branch and forwards that predictor's answer.

The fetch stage drives a branch address on the predict port and reads the final direction in the same cycle. It also reads both component guesses and keeps them with the branch. When the branch resolves, the caller presents the address, the real outcome and the two stored guesses on the update port for one cycle. The block then trains every table and shifts both histories. Branches whose low address bits match share local history and chooser entries.

Top module: `tournament_pred`

## Requirements
- R1: After reset every history is zero and every counter holds 2'b01. The predict port therefore shows local, global and final predictions of 0 and selects the local component (`pred_use_global_o` = 0).
- R2: On a valid update the local history entry selected by `upd_pc_i[LHT_IDX_W-1:0]` shifts left by one, and `upd_taken_i` enters at bit 0. Addresses with equal low bits share that entry.
- R3: On a valid update the global history register shifts left by one and takes `upd_taken_i` into bit 0, whatever the address.
- R4: Every counter is a 2-bit saturating counter. It predicts taken when its MSB is 1, moves up by one on taken (stopping at 2'b11) and down by one on not-taken (stopping at 2'b00).
- R5: `pred_local_o` is the MSB of the local counter indexed by the current history of the local entry for `pred_pc_i`. That counter is trained with the outcome, at the index given by the entry's history before the shift.
- R6: `pred_global_o` is the MSB of the global counter indexed by the global history register. That counter is trained at the index given by the register's value before the shift.
- R7: The chooser entry for `pred_pc_i[CHO_IDX_W-1:0]` selects the global component when its MSB is 1. `pred_taken_o` equals the selected component's prediction.
- R8: The chooser entry is left unchanged when `upd_local_i` equals `upd_global_i`.
- R9: When the two guesses differ, the chooser entry moves one step toward global if `upd_global_i` equals the outcome, and one step toward local otherwise, saturating as in R4.
- R10: With `upd_valid_i` low, no table and no history changes, whatever the other update inputs carry.
- R11: All predict outputs follow `pred_pc_i` within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_pc_i | input | PC_W | Address of the branch being predicted |
| pred_taken_o | output | 1 | Final direction prediction |
| pred_local_o | output | 1 | Local component prediction |
| pred_global_o | output | 1 | Global component prediction |
| pred_use_global_o | output | 1 | Chooser selects global component |
| upd_valid_i | input | 1 | Update strobe for a resolved branch |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Real outcome |
| upd_local_i | input | 1 | Local guess made for this branch |
| upd_global_i | input | 1 | Global guess made for this branch |

## Verification
A fault in any table or history shows up at the predict port on the cycle after the update that caused it, but only when an address that reads that entry is presented. For this reason the bench models every table and compares all four predict outputs on every cycle while the addresses cover aliased values. A history shift that goes wrong changes which counter is indexed, so the local or global prediction diverges within a few updates. A chooser that is trained wrongly flips `pred_use_global_o` within two updates that disagree.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_INIT = 2'b01;

  function automatic ctr_t ctr_next(ctr_t c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    else    return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_msb_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= CTR_INIT;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= ctr_next(mem_q[wr_idx_i], wr_up_i);
    end
  end

  assign rd_msb_o = mem_q[rd_idx_i][1];

  // shadow of last write, checks only
  logic             we_q, up_q;
  logic [IDX_W-1:0] idx_q;
  ctr_t             old_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b0; up_q <= 1'b0; idx_q <= '0; old_q <= CTR_INIT;
    end else begin
      we_q <= wr_en_i; up_q <= wr_up_i; idx_q <= wr_idx_i; old_q <= mem_q[wr_idx_i];
    end
  end

  assert_ctr_hi_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && up_q && old_q == 2'b11) |-> mem_q[idx_q] == 2'b11);
  assert_ctr_lo_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && !up_q && old_q == 2'b00) |-> mem_q[idx_q] == 2'b00);
  assert_ctr_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && up_q) |-> mem_q[idx_q] >= old_q);
  assert_ctr_down_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && !up_q) |-> mem_q[idx_q] <= old_q);
endmodule

// File: rtl/tp_local_hist.sv
module tp_local_hist #(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_bit_i,
  output logic [HIST_W-1:0] wr_hist_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (wr_en_i) begin
      hist_q[wr_idx_i] <= {hist_q[wr_idx_i][HIST_W-2:0], wr_bit_i};
    end
  end

  assign rd_hist_o = hist_q[rd_idx_i];
  assign wr_hist_o = hist_q[wr_idx_i];

  logic             we_q, bit_q;
  logic [IDX_W-1:0] idx_q;
  logic [HIST_W-1:0] old_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b0; bit_q <= 1'b0; idx_q <= '0; old_q <= '0;
    end else begin
      we_q <= wr_en_i; bit_q <= wr_bit_i; idx_q <= wr_idx_i; old_q <= hist_q[wr_idx_i];
    end
  end

  assert_lhist_in_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> hist_q[idx_q][0] == bit_q);
  assert_lhist_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> hist_q[idx_q][HIST_W-1:1] == old_q[HIST_W-2:0]);
endmodule

// File: rtl/tournament_pred.sv
module tournament_pred #(
  parameter int PC_W      = 32,
  parameter int LHT_IDX_W = 6,
  parameter int LHIST_W   = 6,
  parameter int GHIST_W   = 8,
  parameter int CHO_IDX_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pred_pc_i,
  output logic            pred_taken_o,
  output logic            pred_local_o,
  output logic            pred_global_o,
  output logic            pred_use_global_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic            upd_local_i,
  input  logic            upd_global_i
);
  logic [LHT_IDX_W-1:0] p_lidx, u_lidx;
  logic [CHO_IDX_W-1:0] p_cidx, u_cidx;
  logic [LHIST_W-1:0]   p_lhist, u_lhist;
  logic [GHIST_W-1:0]   ghr_q;
  logic                 disagree;

  assign p_lidx   = pred_pc_i[LHT_IDX_W-1:0];
  assign u_lidx   = upd_pc_i[LHT_IDX_W-1:0];
  assign p_cidx   = pred_pc_i[CHO_IDX_W-1:0];
  assign u_cidx   = upd_pc_i[CHO_IDX_W-1:0];
  assign disagree = upd_local_i ^ upd_global_i;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc_i, upd_pc_i};

  tp_local_hist #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
    .clk_i, .rst_ni,
    .rd_idx_i (p_lidx),
    .rd_hist_o(p_lhist),
    .wr_en_i  (upd_valid_i),
    .wr_idx_i (u_lidx),
    .wr_bit_i (upd_taken_i),
    .wr_hist_o(u_lhist)
  );

  tp_ctr_table #(.IDX_W(LHIST_W)) u_lpht (
    .clk_i, .rst_ni,
    .rd_idx_i(p_lhist),
    .rd_msb_o(pred_local_o),
    .wr_en_i (upd_valid_i),
    .wr_idx_i(u_lhist),
    .wr_up_i (upd_taken_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ghr_q <= '0;
    else if (upd_valid_i) ghr_q <= {ghr_q[GHIST_W-2:0], upd_taken_i};
  end

  tp_ctr_table #(.IDX_W(GHIST_W)) u_gpht (
    .clk_i, .rst_ni,
    .rd_idx_i(ghr_q),
    .rd_msb_o(pred_global_o),
    .wr_en_i (upd_valid_i),
    .wr_idx_i(ghr_q),
    .wr_up_i (upd_taken_i)
  );

  // chooser counts up toward global
  tp_ctr_table #(.IDX_W(CHO_IDX_W)) u_cho (
    .clk_i, .rst_ni,
    .rd_idx_i(p_cidx),
    .rd_msb_o(pred_use_global_o),
    .wr_en_i (upd_valid_i && disagree),
    .wr_idx_i(u_cidx),
    .wr_up_i (upd_global_i == upd_taken_i)
  );

  assign pred_taken_o = pred_use_global_o ? pred_global_o : pred_local_o;

  assert_ghr_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> (ghr_q[0] == $past(upd_taken_i)) &&
                    (ghr_q[GHIST_W-1:1] == $past(ghr_q[GHIST_W-2:0])));
  assert_ghr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(ghr_q));
  assert_cho_agree_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !disagree && u_cidx == p_cidx) |=>
      ($stable(pred_pc_i) -> $stable(pred_use_global_o)));
  assert_cho_toward_global_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && disagree && upd_global_i == upd_taken_i && u_cidx == p_cidx
     && pred_use_global_o) |=> ($stable(pred_pc_i) -> pred_use_global_o));
endmodule

// File: tb/tournament_pred_test.sv
`timescale 1ns/1ps
module tournament_pred_test;
  localparam int PC_W = 32, LI_W = 6, LH_W = 6, GH_W = 8, CI_W = 6;
  localparam int LT_N = 1 << LI_W, LP_N = 1 << LH_W, GP_N = 1 << GH_W, CH_N = 1 << CI_W;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0, upd_local = 1'b0, upd_global = 1'b0;
  logic pred_taken, pred_local, pred_global, pred_use_global;

  tournament_pred uut (
    .clk_i(clk), .rst_ni(rst_n),
    .pred_pc_i(pred_pc), .pred_taken_o(pred_taken), .pred_local_o(pred_local),
    .pred_global_o(pred_global), .pred_use_global_o(pred_use_global),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken),
    .upd_local_i(upd_local), .upd_global_i(upd_global)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [LH_W-1:0] m_lht [LT_N];
  logic [1:0]      m_lpht [LP_N];
  logic [1:0]      m_gpht [GP_N];
  logic [1:0]      m_cht [CH_N];
  logic [GH_W-1:0] m_ghr;

  function automatic logic [1:0] sat(logic [1:0] c, logic up);  // R4
    if (up) return (c == 2'b11) ? 2'b11 : c + 2'd1;
    return (c == 2'b00) ? 2'b00 : c - 2'd1;
  endfunction

  function automatic logic exp_local(logic [PC_W-1:0] pc);
    return m_lpht[m_lht[pc[LI_W-1:0]]][1];
  endfunction
  function automatic logic exp_cho(logic [PC_W-1:0] pc);
    return m_cht[pc[CI_W-1:0]][1];
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b (pc=%0h) at %0t", req, got, exp, pred_pc, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < LT_N; i++) m_lht[i] = '0;
    for (int i = 0; i < LP_N; i++) m_lpht[i] = 2'b01;
    for (int i = 0; i < GP_N; i++) m_gpht[i] = 2'b01;
    for (int i = 0; i < CH_N; i++) m_cht[i] = 2'b01;
    m_ghr = '0;
  endtask

  // drive at negedge, compare combinational outputs (R11), model the update edge
  task automatic cyc(input logic [PC_W-1:0] ppc, input logic v, input logic [PC_W-1:0] upc,
                     input logic tk, input logic ul, input logic ug);
    logic el, eg, ec;
    logic [LH_W-1:0] uh;
    @(negedge clk);
    pred_pc = ppc; upd_valid = v; upd_pc = upc; upd_taken = tk; upd_local = ul; upd_global = ug;
    #1;
    el = exp_local(ppc); eg = m_gpht[m_ghr][1]; ec = exp_cho(ppc);
    check(pred_local, el, "R5 local");
    check(pred_global, eg, "R6 global");
    check(pred_use_global, ec, "R9 chooser");
    check(pred_taken, ec ? eg : el, "R7 final R11");
    if (v) begin
      uh = m_lht[upc[LI_W-1:0]];
      m_lpht[uh] = sat(m_lpht[uh], tk);
      m_gpht[m_ghr] = sat(m_gpht[m_ghr], tk);
      if (ul != ug) m_cht[upc[CI_W-1:0]] = sat(m_cht[upc[CI_W-1:0]], ug == tk);  // R8 R9
      m_lht[upc[LI_W-1:0]] = {uh[LH_W-2:0], tk};  // R2
      m_ghr = {m_ghr[GH_W-2:0], tk};               // R3
    end
  endtask

  // update with the guesses the model says the block gave
  task automatic real_upd(input logic [PC_W-1:0] ppc, input logic [PC_W-1:0] upc, input logic tk);
    cyc(ppc, 1'b1, upc, tk, exp_local(upc), m_gpht[m_ghr][1]);
  endtask

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    #10 rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check(pred_local, 1'b0, "R1 local");
    check(pred_global, 1'b0, "R1 global");
    check(pred_use_global, 1'b0, "R1 chooser");
    check(pred_taken, 1'b0, "R1 final");

    // R9: two disagreements where global is right -> global selected
    cyc(32'h0, 1'b1, 32'h0, 1'b1, 1'b0, 1'b1);
    cyc(32'h0, 1'b1, 32'h0, 1'b1, 1'b0, 1'b1);
    cyc(32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    check(pred_use_global, 1'b1, "R9 toward global");
    // R8: agreements leave chooser at global
    for (int i = 0; i < 4; i++) cyc(32'h0, 1'b1, 32'h0, 1'b0, 1'b1, 1'b1);
    check(pred_use_global, 1'b1, "R8 agree no change");
    // R9 saturation toward local, then R4 floor
    for (int i = 0; i < 5; i++) cyc(32'h0, 1'b1, 32'h0, 1'b0, 1'b0, 1'b1);
    check(pred_use_global, 1'b0, "R9 toward local");

    // R4 saturation: long taken run at one PC, then one not-taken
    for (int i = 0; i < 20; i++) real_upd(32'h5, 32'h5, 1'b1);
    real_upd(32'h5, 32'h5, 1'b0);
    cyc(32'h5, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0);
    // R2 aliasing: pc 0x45 shares entry with 0x05
    for (int i = 0; i < 6; i++) real_upd(32'h45, 32'h5 + 32'h40 * i, i[0]);
    cyc(32'h45, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);

    // R10: invalid updates with random fields change nothing
    for (int i = 0; i < 40; i++)
      cyc($urandom % 128, 1'b0, $urandom, 1'($urandom), 1'($urandom), 1'($urandom));

    // random mix: aliased PCs, biased outcomes, mostly genuine guesses
    for (int i = 0; i < 4000; i++) begin
      logic [PC_W-1:0] pp, up;
      logic tk;
      pp = $urandom % 128;
      up = $urandom % 128;
      tk = (($urandom % 4) != 0) ^ up[3];
      if (($urandom % 8) == 0)
        cyc(pp, 1'($urandom), up, tk, 1'($urandom), 1'($urandom));
      else if (($urandom % 5) == 0)
        cyc(pp, 1'b0, up, tk, 1'($urandom), 1'($urandom));  // R10
      else
        real_upd(pp, up, tk);
    end

    // R1 again after a mid-run reset
    @(negedge clk); rst_n = 1'b0; upd_valid = 1'b0;
    model_reset();
    #5 rst_n = 1'b1;
    for (int i = 0; i < 8; i++) cyc(i * 9, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule